// File: doc/BRIEF.md
# Banked Effective Address Sequencer

This block works out the 24-bit effective address of the operand of an accumulator instruction on a 16-bit processor whose memory is split into 64 KiB banks. A start pulse supplies a mode code together with the direct-page base, the stack pointer, both index registers, the data bank byte and the 24-bit program counter. The sequencer then fetches the instruction's operand bytes at the program counter. For the indirect modes it goes on to read a pointer from bank 0, one byte per request.

Memory is reached through a byte-read port. A one-cycle request carries an address, and a valid strobe in some later cycle returns the byte. Only one read is outstanding at any time. When the address is known, the block raises a one-cycle done pulse. At the same time it presents the effective address and the program counter advanced past the operand. Both values hold until the next accepted start. A mode code the block does not support ends the operation at once with an error flag.

Top module: `ea_sequencer`

## Requirements
- R1: After reset, `done`, `err` and `mem_req` are low.
- R2: Operand bytes are read in little-endian order at consecutive program counter values. The counter advances by one after each byte, carrying through all 24 bits. `pc_out` equals the start value plus the operand length: 1 byte for modes 0, 1, 2, 3, 6, 7 and 8, 2 bytes for mode 4, and 3 bytes for mode 5.
- R3: No new `mem_req` is issued while a read is outstanding. A read stays outstanding from its request until `mem_valid` returns.
- R4: Modes 0 (direct page plus X) and 1 (direct page plus Y) give operand byte + D + index. The sum wraps at 16 bits, and the bank byte is 0.
- R5: Mode 2 (stack relative) gives operand byte + S, wrapped at 16 bits, with bank byte 0.
- R6: Mode 3 (stack relative indirect plus Y) places DBR above the 16-bit sum of operand byte and S, then adds Y as a full 24-bit addition. It issues no pointer reads.
- R7: Mode 4 (absolute plus Y) gives {DBR, 16-bit operand} + Y as a 24-bit addition that may carry into the bank byte. Mode 5 (long absolute plus X) gives the 24-bit operand + X.
- R8: Mode 6 (direct-page indirect plus Y) forms P = operand byte + D, wrapped at 16 bits. It reads bytes at bank-0 addresses P and P+1 (P+1 wraps at 16 bits) as the pointer's low and high bytes. The result is {DBR, pointer} + Y as a 24-bit addition.
- R9: Mode 7 (direct-page indirect long plus Y) reads three bytes at bank-0 addresses P, P+1 and P+2, low byte first, to form a 24-bit pointer. The result is that pointer + Y.
- R10: Mode 8 (direct-page indexed indirect by X) forms P = operand byte + D + X, wrapped at 16 bits. It reads a 2-byte pointer there, and the result is {DBR, pointer} with no index added.
- R11: Mode codes 9 to 15 raise `err` together with `done` in the cycle after the start. No memory read is issued, and `pc_out` equals the start value.
- R12: `done` is high for exactly one cycle per operation. A `start` that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 4 | Addressing mode code |
| reg_d | input | 16 | Direct-page base |
| reg_s | input | 16 | Stack pointer |
| reg_x | input | 16 | X index |
| reg_y | input | 16 | Y index |
| reg_dbr | input | 8 | Data bank byte |
| pc_in | input | 24 | Program counter at the first operand byte |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 24 | Address of the requested byte |
| mem_valid | input | 1 | Read data is valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported mode, held with the result |
| eff_addr | output | 24 | Effective address |
| pc_out | output | 24 | Program counter after the operand |

## Verification
Two situations are hard to reach from the ports. The first is a pointer fetch that straddles the top of bank 0, where the second pointer byte must come from address 0 and not from 0x10000. The stimulus sets D to 0xFFFF with a zero operand, and the bench checks the logged request addresses. The second is a start pulse that arrives in the middle of a slow pointer fetch. A responder with several cycles of latency keeps the sequencer busy while a second, different start is driven. Another case sets the program counter to the last byte of a bank so that the operand fetch crosses a bank boundary.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_DP_X      = 4'd0,
        MD_DP_Y      = 4'd1,
        MD_SR        = 4'd2,
        MD_SR_IND_Y  = 4'd3,
        MD_ABS_Y     = 4'd4,
        MD_ABSL_X    = 4'd5,
        MD_DP_IND_Y  = 4'd6,
        MD_DP_INDL_Y = 4'd7,
        MD_DP_X_IND  = 4'd8
    } ea_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/ea_seq_decode.sv
module ea_seq_decode
    import ea_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [MODE_W-1:0] mode,
    output logic              legal,
    output logic [CNT_W-1:0]  op_bytes,
    output logic [CNT_W-1:0]  ptr_bytes
);

    always_comb begin
        legal     = 1'b1;
        op_bytes  = CNT_W'(1);
        ptr_bytes = '0;
        case (mode)
            MD_DP_X, MD_DP_Y, MD_SR, MD_SR_IND_Y: begin
                op_bytes = CNT_W'(1);
            end
            MD_ABS_Y: begin
                op_bytes = CNT_W'(2);
            end
            MD_ABSL_X: begin
                op_bytes = CNT_W'(3);
            end
            MD_DP_IND_Y, MD_DP_X_IND: begin
                ptr_bytes = CNT_W'(2);
            end
            MD_DP_INDL_Y: begin
                ptr_bytes = CNT_W'(3);
            end
            default: begin
                legal    = 1'b0;
                op_bytes = '0;
            end
        endcase
    end

endmodule

// File: rtl/ea_seq_calc.sv
module ea_seq_calc
    import ea_seq_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic [MODE_W-1:0]       mode,
    input  logic [ADDR_W-1:0]       op,
    input  logic [ADDR_W-1:0]       ptr,
    input  logic [REG_W-1:0]        d,
    input  logic [REG_W-1:0]        s,
    input  logic [REG_W-1:0]        x,
    input  logic [REG_W-1:0]        y,
    input  logic [ADDR_W-REG_W-1:0] dbr,
    output logic [ADDR_W-1:0]       ea,
    output logic [REG_W-1:0]        ptr_base
);

    localparam int BANK_W = ADDR_W - REG_W;

    logic [REG_W-1:0] op_lo;
    logic [REG_W-1:0] dp_x_sum;
    logic [REG_W-1:0] dp_y_sum;
    logic [REG_W-1:0] sr_sum;

    assign op_lo    = REG_W'(op[DATA_W-1:0]);
    assign dp_x_sum = op_lo + d + x;
    assign dp_y_sum = op_lo + d + y;
    assign sr_sum   = op_lo + s;

    always_comb begin
        if (mode == MD_DP_X_IND) begin
            ptr_base = dp_x_sum;
        end else begin
            ptr_base = op_lo + d;
        end
    end

    always_comb begin
        case (mode)
            MD_DP_X:      ea = {{BANK_W{1'b0}}, dp_x_sum};
            MD_DP_Y:      ea = {{BANK_W{1'b0}}, dp_y_sum};
            MD_SR:        ea = {{BANK_W{1'b0}}, sr_sum};
            MD_SR_IND_Y:  ea = {dbr, sr_sum} + ADDR_W'(y);
            MD_ABS_Y:     ea = {dbr, op[REG_W-1:0]} + ADDR_W'(y);
            MD_ABSL_X:    ea = op + ADDR_W'(x);
            MD_DP_IND_Y:  ea = {dbr, ptr[REG_W-1:0]} + ADDR_W'(y);
            MD_DP_INDL_Y: ea = ptr + ADDR_W'(y);
            MD_DP_X_IND:  ea = {dbr, ptr[REG_W-1:0]};
            default:      ea = '0;
        endcase
    end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_seq_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [MODE_W-1:0]       mode,
    input  logic [REG_W-1:0]        reg_d,
    input  logic [REG_W-1:0]        reg_s,
    input  logic [REG_W-1:0]        reg_x,
    input  logic [REG_W-1:0]        reg_y,
    input  logic [ADDR_W-REG_W-1:0] reg_dbr,
    input  logic [ADDR_W-1:0]       pc_in,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_valid,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    done,
    output logic                    err,
    output logic [ADDR_W-1:0]       eff_addr,
    output logic [ADDR_W-1:0]       pc_out
);

    localparam int BANK_W = ADDR_W - REG_W;
    localparam int NBYTES = ADDR_W / DATA_W;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    typedef struct packed {
        seq_state_t          state;
        logic [MODE_W-1:0]   mode;
        logic                in_ptr;
        logic [CNT_W-1:0]    cnt;
        logic [REG_W-1:0]    d;
        logic [REG_W-1:0]    s;
        logic [REG_W-1:0]    x;
        logic [REG_W-1:0]    y;
        logic [BANK_W-1:0]   dbr;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   op;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   ea;
        logic                done;
        logic                err;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic             start_legal;
    logic [CNT_W-1:0] start_op_bytes;
    logic [CNT_W-1:0] start_ptr_bytes;
    logic             cur_legal;
    logic [CNT_W-1:0] cur_op_bytes;
    logic [CNT_W-1:0] cur_ptr_bytes;
    logic [ADDR_W-1:0] calc_ea;
    logic [REG_W-1:0]  ptr_base;
    logic [CNT_W-1:0]  last_cnt;
    logic              busy;

    ea_seq_decode #(.CNT_W(CNT_W)) i_dec_start (
        .mode      (mode),
        .legal     (start_legal),
        .op_bytes  (start_op_bytes),
        .ptr_bytes (start_ptr_bytes)
    );

    ea_seq_decode #(.CNT_W(CNT_W)) i_dec_cur (
        .mode      (seq_q.mode),
        .legal     (cur_legal),
        .op_bytes  (cur_op_bytes),
        .ptr_bytes (cur_ptr_bytes)
    );

    ea_seq_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_calc (
        .mode     (seq_q.mode),
        .op       (seq_q.op),
        .ptr      (seq_q.ptr),
        .d        (seq_q.d),
        .s        (seq_q.s),
        .x        (seq_q.x),
        .y        (seq_q.y),
        .dbr      (seq_q.dbr),
        .ea       (calc_ea),
        .ptr_base (ptr_base)
    );

    assign last_cnt = seq_q.in_ptr ? (cur_ptr_bytes - CNT_W'(1))
                                   : (cur_op_bytes - CNT_W'(1));
    assign busy     = (seq_q.state != ST_IDLE);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        mem_req    = 1'b0;
        mem_addr   = seq_q.pc;
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.mode   = mode;
                    seq_d.d      = reg_d;
                    seq_d.s      = reg_s;
                    seq_d.x      = reg_x;
                    seq_d.y      = reg_y;
                    seq_d.dbr    = reg_dbr;
                    seq_d.pc     = pc_in;
                    seq_d.op     = '0;
                    seq_d.ptr    = '0;
                    seq_d.cnt    = '0;
                    seq_d.in_ptr = 1'b0;
                    seq_d.err    = 1'b0;
                    if (start_legal) begin
                        seq_d.state = ST_REQ;
                    end else begin
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                        seq_d.ea   = '0;
                    end
                end
            end
            ST_REQ: begin
                mem_req = 1'b1;
                if (seq_q.in_ptr) begin
                    mem_addr = {{BANK_W{1'b0}}, ptr_base + REG_W'(seq_q.cnt)};
                end else begin
                    mem_addr = seq_q.pc;
                    seq_d.pc = seq_q.pc + ADDR_W'(1);
                end
                seq_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_valid) begin
                    for (int b = 0; b < NBYTES; b++) begin
                        if (seq_q.cnt == CNT_W'(b)) begin
                            if (seq_q.in_ptr) begin
                                seq_d.ptr[DATA_W*b +: DATA_W] = mem_rdata;
                            end else begin
                                seq_d.op[DATA_W*b +: DATA_W] = mem_rdata;
                            end
                        end
                    end
                    if (seq_q.cnt == last_cnt) begin
                        seq_d.cnt = '0;
                        if (!seq_q.in_ptr && (cur_ptr_bytes != '0)) begin
                            seq_d.in_ptr = 1'b1;
                            seq_d.state  = ST_REQ;
                        end else begin
                            seq_d.state = ST_FIN;
                        end
                    end else begin
                        seq_d.cnt   = seq_q.cnt + CNT_W'(1);
                        seq_d.state = ST_REQ;
                    end
                end
            end
            ST_FIN: begin
                seq_d.done  = 1'b1;
                seq_d.err   = !cur_legal;
                seq_d.ea    = calc_ea;
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done     = seq_q.done;
    assign err      = seq_q.err;
    assign eff_addr = seq_q.ea;
    assign pc_out   = seq_q.pc;

endmodule

// File: rtl/ea_seq_checker.sv
module ea_seq_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] pc_in,
    input logic              mem_req,
    input logic              mem_valid,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] pc_out,
    input logic              busy
);

    logic              pending_q;
    logic [ADDR_W-1:0] pc_start_q;
    logic [ADDR_W-1:0] pc_adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q  <= 1'b0;
            pc_start_q <= '0;
        end else begin
            if (mem_req) begin
                pending_q <= 1'b1;
            end else if (mem_valid) begin
                pending_q <= 1'b0;
            end
            if (start && !busy) begin
                pc_start_q <= pc_in;
            end
        end
    end

    assign pc_adv = pc_out - pc_start_q;

    // R3
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pending_q);

    // R3
    req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R11
    err_pc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (pc_out == pc_start_q));

    // R2
    pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((pc_adv >= ADDR_W'(1)) && (pc_adv <= ADDR_W'(3))));

endmodule

bind ea_sequencer ea_seq_checker #(.ADDR_W(ADDR_W)) i_ea_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pc_in     (pc_in),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .done      (done),
    .err       (err),
    .pc_out    (pc_out),
    .busy      (busy)
);

// File: tb/test_ea_sequencer.sv
`timescale 1ns/1ps
module test_ea_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] reg_d = '0, reg_s = '0, reg_x = '0, reg_y = '0;
    logic [7:0]  reg_dbr = '0;
    logic [23:0] pc_in = '0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done, err;
    logic [23:0] eff_addr, pc_out;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int req_cnt = 0;
    logic [23:0] addr_log[$];
    logic [7:0]  mem [int unsigned];

    always #2 clk = ~clk;

    ea_sequencer i_ea_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .reg_d(reg_d), .reg_s(reg_s), .reg_x(reg_x), .reg_y(reg_y),
        .reg_dbr(reg_dbr), .pc_in(pc_in),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .err(err), .eff_addr(eff_addr), .pc_out(pc_out)
    );

    function automatic logic [7:0] rd(input logic [23:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    // byte-read responder with programmable latency (at least 1)
    initial begin
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (mem_req) begin
                logic [23:0] a;
                a = mem_addr;
                req_cnt++;
                addr_log.push_back(a);
                repeat (lat) @(negedge clk);
                mem_valid = 1'b1;
                mem_rdata = rd(a);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_bench();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic setup(input logic [3:0] m, input logic [23:0] pc,
                         input logic [15:0] d, input logic [15:0] s,
                         input logic [15:0] x, input logic [15:0] y,
                         input logic [7:0] dbr);
        mode = m; pc_in = pc; reg_d = d; reg_s = s;
        reg_x = x; reg_y = y; reg_dbr = dbr;
        req_cnt = 0;
        addr_log.delete();
    endtask

    task automatic pulse_and_wait(output bit seen);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_case(input string req, input logic [3:0] m, input logic [23:0] pc,
                            input logic [15:0] d, input logic [15:0] s,
                            input logic [15:0] x, input logic [15:0] y,
                            input logic [7:0] dbr,
                            input logic [23:0] exp_ea, input logic [23:0] exp_pc,
                            input int exp_reads);
        bit seen;
        setup(m, pc, d, s, x, y, dbr);
        pulse_and_wait(seen);
        chk({req, " done"}, 32'(seen), 32'd1);
        chk({req, " ea"}, 32'(eff_addr), 32'(exp_ea));
        chk({req, " pc"}, 32'(pc_out), 32'(exp_pc));
        chk({req, " err"}, 32'(err), 32'd0);
        chk({req, " reads"}, 32'(req_cnt), 32'(exp_reads));
        @(negedge clk);
        chk({req, " R12 done one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic test_reset();
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
    endtask

    task automatic test_dp_indexed();
        mem.delete();
        mem[32'h808000] = 8'h20;
        run_case("R4 dp+x", 4'd0, 24'h808000, 16'h1000, 16'h0, 16'h0005, 16'h0, 8'hAA,
                 24'h001025, 24'h808001, 1);
        mem[32'h400000] = 8'h05;
        run_case("R4 dp+y wrap", 4'd1, 24'h400000, 16'hFFF0, 16'h0, 16'h0, 16'h0020, 8'hAA,
                 24'h000015, 24'h400001, 1);
    endtask

    task automatic test_stack();
        mem.delete();
        mem[32'h808000] = 8'h05;
        run_case("R5 sr", 4'd2, 24'h808000, 16'h0, 16'h1FF0, 16'h0, 16'h0, 8'h55,
                 24'h001FF5, 24'h808001, 1);
        mem[32'h808000] = 8'h06;
        run_case("R6 sr ind y", 4'd3, 24'h808000, 16'h0, 16'h1010, 16'h0, 16'h0005, 8'h88,
                 24'h88101B, 24'h808001, 1);
    endtask

    task automatic test_absolute();
        mem.delete();
        mem[32'h80FFFF] = 8'h34;
        mem[32'h810000] = 8'h12;
        lat = 2;
        run_case("R7 abs+y carry", 4'd4, 24'h80FFFF, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'h7F,
                 24'h801233, 24'h810001, 2);
        chk("R2 second operand addr", 32'(addr_log[1]), 32'h00810000);
        lat = 1;
        mem[32'h808000] = 8'h10;
        mem[32'h808001] = 8'hAC;
        mem[32'h808002] = 8'hEF;
        run_case("R7 long+x", 4'd5, 24'h808000, 16'h0, 16'h0, 16'h0005, 16'h0, 8'h00,
                 24'hEFAC15, 24'h808003, 3);
        chk("R2 third operand addr", 32'(addr_log[2]), 32'h00808002);
    endtask

    task automatic test_dp_indirect();
        mem.delete();
        mem[32'h808000] = 8'h10;
        mem[32'h001010] = 8'h30;
        mem[32'h001011] = 8'h40;
        mem[32'h001012] = 8'h23;
        run_case("R8 dp ind y", 4'd6, 24'h808000, 16'h1000, 16'h0, 16'h0, 16'h0001, 8'h80,
                 24'h804031, 24'h808001, 3);
        chk("R8 pointer low addr", 32'(addr_log[1]), 32'h00001010);
        run_case("R9 dp ind long", 4'd7, 24'h808000, 16'h1000, 16'h0, 16'h0, 16'h0000, 8'h80,
                 24'h234030, 24'h808001, 4);
        chk("R9 pointer high addr", 32'(addr_log[3]), 32'h00001012);
        mem[32'h001010] = 8'hFF;
        mem[32'h001011] = 8'hFF;
        run_case("R9 dp ind long +y", 4'd7, 24'h808000, 16'h1000, 16'h0, 16'h0, 16'hFFFF, 8'h80,
                 24'h24FFFE, 24'h808001, 4);
        mem.delete();
        mem[32'h808000] = 8'h10;
        mem[32'h001013] = 8'h30;
        mem[32'h001014] = 8'h40;
        run_case("R10 dp x ind", 4'd8, 24'h808000, 16'h1000, 16'h0, 16'h0003, 16'h7777, 8'h80,
                 24'h804030, 24'h808001, 3);
        chk("R10 pointer addr", 32'(addr_log[1]), 32'h00001013);
    endtask

    task automatic test_pointer_wrap();
        mem.delete();
        mem[32'h100000] = 8'h00;
        mem[32'h00FFFF] = 8'h78;
        mem[32'h000000] = 8'h56;
        run_case("R8 wrap", 4'd6, 24'h100000, 16'hFFFF, 16'h0, 16'h0, 16'h0002, 8'h12,
                 24'h12567A, 24'h100001, 3);
        chk("R8 wrap second pointer addr", 32'(addr_log[2]), 32'h00000000);
    endtask

    task automatic test_illegal();
        bit seen;
        for (int m = 9; m < 16; m += 6) begin
            setup(4'(m), 24'h123456, 16'h1, 16'h2, 16'h3, 16'h4, 8'h5);
            pulse_and_wait(seen);
            chk("R11 done", 32'(seen), 32'd1);
            chk("R11 err", 32'(err), 32'd1);
            chk("R11 no reads", 32'(req_cnt), 32'd0);
            chk("R11 pc kept", 32'(pc_out), 32'h00123456);
        end
    endtask

    task automatic test_busy_start();
        int extra;
        mem.delete();
        mem[32'h808000] = 8'h10;
        mem[32'h001010] = 8'h30;
        mem[32'h001011] = 8'h40;
        mem[32'h300000] = 8'h01;
        lat = 4;
        setup(4'd6, 24'h808000, 16'h1000, 16'h0, 16'h0, 16'h0001, 8'h80);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        mode = 4'd2; pc_in = 24'h300000; reg_s = 16'h4000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R12 busy start ignored ea", 32'(eff_addr), 32'h00804031);
        chk("R12 busy start ignored pc", 32'(pc_out), 32'h00808001);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R12 single done", 32'(extra), 32'd0);
        lat = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_bench();
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_dp_indexed();
        test_stack();
        test_absolute();
        test_dp_indirect();
        test_pointer_wrap();
        test_illegal();
        test_busy_start();
        finish_bench();
    end

endmodule